// File: doc/BRIEF.md
# Stepper Step Translator with Decay Selection

This block turns a stream of step pulses into the winding current sequence of a two-phase bipolar stepper motor. It keeps a position index on a ring of eight half-step positions and, for each phase, presents a magnitude code and a polarity bit that a downstream current DAC consumes. Every step also produces a decay choice for each phase: slow when the phase's current holds or grows, and mixed when it shrinks. This lets the current regulator after the block track a falling current quickly without adding ripple on a rising one.

The step line passes through a synchronizer and a rising-edge detector. Direction and resolution select are sampled only in the cycle the step is applied. In full-step mode the index visits only the four diagonal positions, where both phases are on. An active-low reset input returns the index to the diagonal home position and holds it there. A disable input removes the drive flag but leaves the translator running.

Top module: `stp_translator`

## Requirements
- R1: While `rst_n` is low, the block holds `pos_idx` at 1 (home, both phases at magnitude code 1, positive), holds `a_mixed` and `b_mixed` at 1, holds `drive_on` at 0, and ignores any step edge. No step edge seen during reset advances the index after release.
- R2: For index 0..7, phase A gives (magnitude code, `a_neg`) of (2,0),(1,0),(0,0),(1,1),(2,1),(1,1),(0,0),(1,0). Phase B gives (0,0),(1,0),(2,0),(1,0),(0,0),(1,1),(2,1),(1,1). Code 0 means zero current, 1 means the diagonal level and 2 means full current. A zero-current phase always has its polarity bit at 0.
- R3: Only a low-to-high transition of `step_in` advances the index. With two synchronizer stages, the index changes on the third rising clock edge after `step_in` rises. Holding `step_in` high, or letting it fall, never moves the index again.
- R4: When the step is applied, `dir_in` = 1 moves the index upward and `dir_in` = 0 moves it downward, both modulo 8.
- R5: With `half_sel` = 1 each step moves the index by exactly one position.
- R6: With `half_sel` = 0 and the index odd (diagonal), each step moves it by two, so it stays odd.
- R7: With `half_sel` = 0 and the index even (an axis position), the next step moves it by one, to the neighbouring odd position in the chosen direction.
- R8: On each step, a phase's mixed flag becomes 1 if its new magnitude code is lower than the previous one, and 0 otherwise. Polarity is not compared. Between steps the flags hold.
- R9: `dis_in` has no effect on the index, levels or decay flags. `drive_on` is 1 exactly when, at the previous clock edge, `rst_n` was 1 and `dis_in` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset to home |
| step_in | input | 1 | Step request, asynchronous to clk |
| dir_in | input | 1 | Direction, 1 = increasing index |
| half_sel | input | 1 | 1 = half step, 0 = full step |
| dis_in | input | 1 | Drive disable, 1 = drive off |
| pos_idx | output | 3 | Current position index |
| a_mag | output | 2 | Phase A magnitude code |
| a_neg | output | 1 | Phase A polarity, 1 = negative |
| a_mixed | output | 1 | Phase A decay, 1 = mixed, 0 = slow |
| b_mag | output | 2 | Phase B magnitude code |
| b_neg | output | 1 | Phase B polarity, 1 = negative |
| b_mixed | output | 1 | Phase B decay, 1 = mixed, 0 = slow |
| drive_on | output | 1 | Bridge drive permitted |

## Verification
The bench pulses the step line during reset and releases reset with the line still high. A design that clears its synchronizer on reset would see a false edge and leave home. It walks both directions across the 7-to-0 wrap, where a design using a wrong-width adder would land on the wrong position. It switches to full step while sitting on an axis position, which a design with a fixed stride of two would never leave, and it covers steps that lower one phase while raising the other, where swapped or polarity-based comparisons would flag the wrong phase as mixed. It also steps with the drive disabled, to catch a design that gates the translator with the disable input.

// File: rtl/stp_pkg.sv
package stp_pkg;
   localparam int NUM_PH  = 2;
   localparam int NUM_POS = 8;
   localparam int IDX_W   = $clog2(NUM_POS);
   localparam int MAG_W   = 2;
   localparam int QUARTER = NUM_POS / 4;

   typedef logic [IDX_W-1:0] pos_t;
   typedef logic [MAG_W-1:0] mag_t;

   typedef enum logic [MAG_W-1:0] {
      LVL_ZERO = 2'd0,
      LVL_DIAG = 2'd1,
      LVL_FULL = 2'd2
   } lvl_e;

   // Cosine-shaped level at ring position k (phase A shape).
   function automatic mag_t ring_mag(pos_t k);
      if (k[0])      return mag_t'(LVL_DIAG);
      else if (k[1]) return mag_t'(LVL_ZERO);
      else           return mag_t'(LVL_FULL);
   endfunction

   function automatic logic ring_neg(pos_t k);
      return (k == pos_t'(3)) || (k == pos_t'(4)) || (k == pos_t'(5));
   endfunction
endpackage

// File: rtl/stp_edge_sync.sv
module stp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic raw_in,
   output logic rise_pls
);
   initial assert (STAGES >= 2) else $error("stp_edge_sync: STAGES must be at least 2");

   // Free-running chain: no reset, so a level held through reset never
   // looks like an edge once reset is released.
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-1:0], raw_in};
   end

   assign rise_pls = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/stp_index.sv
module stp_index
   import stp_pkg::*;
#(
   parameter int HOME_IDX = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic up,
   input  logic fine,
   output pos_t pos_q,
   output pos_t pos_nxt
);
   initial assert (HOME_IDX % 2 == 1 && HOME_IDX < NUM_POS)
      else $error("stp_index: home must be a diagonal position");

   pos_t stride;

   always_comb begin
      stride  = (fine || !pos_q[0]) ? pos_t'(1) : pos_t'(2);
      pos_nxt = up ? pos_t'(pos_q + stride) : pos_t'(pos_q - stride);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   pos_q <= pos_t'(HOME_IDX);
      else if (adv) pos_q <= pos_nxt;
   end
endmodule

// File: rtl/stp_level_map.sv
module stp_level_map
   import stp_pkg::*;
(
   input  pos_t               pos,
   output mag_t [NUM_PH-1:0]  mag,
   output logic [NUM_PH-1:0]  neg
);
   for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      pos_t k;
      assign k      = pos_t'(pos - pos_t'(p * QUARTER));
      assign mag[p] = ring_mag(k);
      assign neg[p] = ring_neg(k);
   end
endmodule

// File: rtl/stp_decay_sel.sv
module stp_decay_sel
   import stp_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  mag_t [NUM_PH-1:0]  old_mag,
   input  mag_t [NUM_PH-1:0]  new_mag,
   output logic [NUM_PH-1:0]  mixed
);
   for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      always_ff @(posedge clk) begin
         if (!rst_n)   mixed[p] <= 1'b1;
         else if (adv) mixed[p] <= (new_mag[p] < old_mag[p]);
      end
   end
endmodule

// File: rtl/stp_translator.sv
module stp_translator
   import stp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOME_IDX    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dir_in,
   input  logic             half_sel,
   input  logic             dis_in,
   output logic [IDX_W-1:0] pos_idx,
   output logic [MAG_W-1:0] a_mag,
   output logic             a_neg,
   output logic             a_mixed,
   output logic [MAG_W-1:0] b_mag,
   output logic             b_neg,
   output logic             b_mixed,
   output logic             drive_on
);
   initial assert (NUM_PH == 2) else $error("stp_translator: port list assumes two phases");

   logic              step_pls;
   pos_t              pos_cur;
   pos_t              pos_nxt;
   mag_t [NUM_PH-1:0] cur_mag;
   mag_t [NUM_PH-1:0] nxt_mag;
   logic [NUM_PH-1:0] cur_neg;
   logic [NUM_PH-1:0] nxt_neg;
   logic [NUM_PH-1:0] mix_q;
   logic              drv_q;

   stp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .raw_in   (step_in),
      .rise_pls (step_pls)
   );

   stp_index #(.HOME_IDX(HOME_IDX)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (step_pls),
      .up      (dir_in),
      .fine    (half_sel),
      .pos_q   (pos_cur),
      .pos_nxt (pos_nxt)
   );

   stp_level_map u_map_cur (
      .pos (pos_cur),
      .mag (cur_mag),
      .neg (cur_neg)
   );

   stp_level_map u_map_nxt (
      .pos (pos_nxt),
      .mag (nxt_mag),
      .neg (nxt_neg)
   );

   stp_decay_sel u_decay (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (step_pls),
      .old_mag (cur_mag),
      .new_mag (nxt_mag),
      .mixed   (mix_q)
   );

   always_ff @(posedge clk) begin
      drv_q <= rst_n & ~dis_in;
   end

   logic unused_nxt;
   assign unused_nxt = ^nxt_neg;

   assign pos_idx  = pos_cur;
   assign a_mag    = cur_mag[0];
   assign a_neg    = cur_neg[0];
   assign a_mixed  = mix_q[0];
   assign b_mag    = cur_mag[1];
   assign b_neg    = cur_neg[1];
   assign b_mixed  = mix_q[1];
   assign drive_on = drv_q;
endmodule

// File: rtl/stp_translator_chk.sv
module stp_translator_chk
   import stp_pkg::*;
#(
   parameter int HOME_IDX = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             half_sel,
   input logic             dis_in,
   input logic [IDX_W-1:0] pos_idx,
   input logic [MAG_W-1:0] a_mag,
   input logic [MAG_W-1:0] b_mag,
   input logic             a_mixed,
   input logic             b_mixed,
   input logic             drive_on
);
   // R1
   home_hold_chk: assert property (@(posedge clk)
      !rst_n |=> (pos_idx == pos_t'(HOME_IDX) && a_mixed && b_mixed && !drive_on));

   // R5
   fine_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_idx != $past(pos_idx)) && $past(half_sel) |->
         (pos_t'(pos_idx - $past(pos_idx)) == pos_t'(1) ||
          pos_t'($past(pos_idx) - pos_idx) == pos_t'(1)));

   // R6 R7
   coarse_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_idx != $past(pos_idx)) && !$past(half_sel) |-> pos_idx[0]);

   // R8
   decay_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_idx != $past(pos_idx)) |-> (a_mixed == (a_mag < $past(a_mag))));

   // R8
   decay_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_idx != $past(pos_idx)) |-> (b_mixed == (b_mag < $past(b_mag))));

   // R8
   decay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_idx == $past(pos_idx)) |-> ($stable(a_mixed) && $stable(b_mixed)));

   // R9
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_in |=> !drive_on);
endmodule

bind stp_translator stp_translator_chk #(.HOME_IDX(HOME_IDX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .half_sel (half_sel),
   .dis_in   (dis_in),
   .pos_idx  (pos_idx),
   .a_mag    (a_mag),
   .b_mag    (b_mag),
   .a_mixed  (a_mixed),
   .b_mixed  (b_mixed),
   .drive_on (drive_on)
);

// File: tb/stp_translator_test.sv
`timescale 1ns/1ps
module stp_translator_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_in = 1'b0;
   logic       dir_in = 1'b1;
   logic       half_sel = 1'b1;
   logic       dis_in = 1'b0;
   logic [2:0] pos_idx;
   logic [1:0] a_mag, b_mag;
   logic       a_neg, b_neg, a_mixed, b_mixed, drive_on;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   stp_translator uut (
      .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
      .half_sel(half_sel), .dis_in(dis_in), .pos_idx(pos_idx),
      .a_mag(a_mag), .a_neg(a_neg), .a_mixed(a_mixed),
      .b_mag(b_mag), .b_neg(b_neg), .b_mixed(b_mixed), .drive_on(drive_on)
   );

   typedef struct {
      string      tag;
      logic [2:0] idx;
      logic [1:0] am;
      logic       an;
      logic       ax;
      logic [1:0] bm;
      logic       bn;
      logic       bx;
      logic       drv;
   } exp_t;

   exp_t sb_q[$];

   // Level table per R2, written out as the requirement states it.
   logic [1:0] tbl_am [8] = '{2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0, 2'd1};
   logic       tbl_an [8] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   logic [1:0] tbl_bm [8] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1};
   logic       tbl_bn [8] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

   int m_idx = 1;
   bit m_ax  = 1'b1;
   bit m_bx  = 1'b1;

   task automatic push_exp(string tag);
      exp_t e;
      e.tag = tag;
      e.idx = 3'(m_idx);
      e.am  = tbl_am[m_idx];
      e.an  = tbl_an[m_idx];
      e.bm  = tbl_bm[m_idx];
      e.bn  = tbl_bn[m_idx];
      e.ax  = m_ax;
      e.bx  = m_bx;
      e.drv = rst_n && !dis_in;
      sb_q.push_back(e);
   endtask

   // Driver: one step, then model update per R3..R8 and push.
   task automatic do_step(bit up, bit fine, int hold, string tag);
      int stride;
      int nidx;
      @(negedge clk);
      dir_in   = up;
      half_sel = fine;
      step_in  = 1'b1;
      repeat (hold) @(negedge clk);
      step_in = 1'b0;
      repeat (5) @(negedge clk);
      stride = (fine || (m_idx % 2 == 0)) ? 1 : 2;
      nidx   = up ? (m_idx + stride) % 8 : (m_idx + 8 - stride) % 8;
      m_ax   = tbl_am[nidx] < tbl_am[m_idx];
      m_bx   = tbl_bm[nidx] < tbl_bm[m_idx];
      m_idx  = nidx;
      push_exp(tag);
   endtask

   // Monitor: pop and compare shortly after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (pos_idx !== e.idx || a_mag !== e.am || a_neg !== e.an || a_mixed !== e.ax ||
                b_mag !== e.bm || b_neg !== e.bn || b_mixed !== e.bx || drive_on !== e.drv) begin
               errors++;
               $display("FAIL %s: got idx=%0d A=%0d/%0b/%0b B=%0d/%0b/%0b drv=%0b expected idx=%0d A=%0d/%0b/%0b B=%0d/%0b/%0b drv=%0b",
                        e.tag, pos_idx, a_mag, a_neg, a_mixed, b_mag, b_neg, b_mixed, drive_on,
                        e.idx, e.am, e.an, e.ax, e.bm, e.bn, e.bx, e.drv);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      step_in = 1'b1;                 // edge during reset must be ignored
      repeat (4) @(negedge clk);
      push_exp("R1 reset home state");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;                   // release with step still high
      repeat (5) @(negedge clk);
      push_exp("R1 no advance after release with step high");
      step_in = 1'b0;
      repeat (5) @(negedge clk);
      push_exp("R3 falling edge does not advance");

      // Half steps upward through the wrap (R2 R4 R5 R8)
      do_step(1'b1, 1'b1, 2, "R5 half up 1->2");
      do_step(1'b1, 1'b1, 2, "R2 half up 2->3");
      do_step(1'b1, 1'b1, 2, "R8 half up 3->4");
      do_step(1'b1, 1'b1, 2, "R2 half up 4->5");
      do_step(1'b1, 1'b1, 2, "R8 half up 5->6");
      do_step(1'b1, 1'b1, 2, "R2 half up 6->7");
      do_step(1'b1, 1'b1, 2, "R4 half up wrap 7->0");
      do_step(1'b0, 1'b1, 2, "R4 half down wrap 0->7");
      do_step(1'b0, 1'b1, 20, "R3 long high level one step 7->6");

      // Full step from an axis position (R7), then by two (R6)
      do_step(1'b0, 1'b0, 2, "R7 full from axis 6->5");
      do_step(1'b0, 1'b0, 2, "R6 full down 5->3");
      do_step(1'b0, 1'b0, 2, "R6 full down 3->1");
      do_step(1'b0, 1'b0, 2, "R6 full down wrap 1->7");
      do_step(1'b1, 1'b0, 2, "R6 full up wrap 7->1");
      do_step(1'b1, 1'b1, 2, "R5 half up to axis 1->2");
      do_step(1'b0, 1'b0, 2, "R7 full down from axis 2->1");

      // Disable has no effect on translation (R9)
      @(negedge clk);
      dis_in = 1'b1;
      repeat (2) @(negedge clk);
      push_exp("R9 drive off when disabled");
      do_step(1'b1, 1'b0, 2, "R9 full step while disabled 1->3");
      do_step(1'b1, 1'b1, 2, "R9 half step while disabled 3->4");
      @(negedge clk);
      dis_in = 1'b0;
      repeat (2) @(negedge clk);
      push_exp("R9 drive back on");

      // Reset from a non-home position (R1)
      @(negedge clk);
      rst_n = 1'b0;
      m_idx = 1; m_ax = 1'b1; m_bx = 1'b1;
      repeat (3) @(negedge clk);
      push_exp("R1 reset returns home");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule